// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block picks one of two clock sources, a fast system clock or a slower scan/test clock, and drives the chosen clock onto a bank of identical output pairs. Each pair has a true output and a complement output. A single active-low enable gates the whole bank.

The enable is not applied directly. A flip-flop clocked on the falling edge of the selected clock samples it, and the flip-flop output is ANDed with the selected clock. As a result, the outputs can only switch on or off while the clock is already low. This keeps shortened high pulses off the distributed clock.

An asynchronous active-high reset puts the gate in the disabled state. The block is placed at the root of a clock tree, where test logic must be able to stop and start the tree without producing a runt pulse.

Top module: `gclk_fanout`

## Requirements
- R1: With `sel_scan` = 0 and the gate enabled, every true output equals `clk_sys`.
- R2: With `sel_scan` = 1 and the gate enabled, every true output equals `clk_scan`.
- R3: While the gate is disabled, every true output is 0, whatever the clocks and `sel_scan` do.
- R4: A change on `en_n` takes effect only at the next falling edge of the selected clock. The value of `en_n` sampled there decides the gate state (0 = enabled, 1 = disabled) until the following falling edge.
- R5: While `sel_scan` is held constant, every high pulse on a true output lasts exactly the high phase of the selected clock, even when `en_n` toggles at arbitrary times.
- R6: Each complement output is always the inverse of its true output, for all output pairs.
- R7: `rst` = 1 forces the gate to disabled at once. After release, the true outputs stay 0 until a falling edge of the selected clock samples `en_n` = 0.
- R8: With all inputs held low (clocks stopped low, `sel_scan` = 0, `en_n` = 0), all true outputs are 0 and all complement outputs are 1.
- R9: All true outputs carry the same value at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Primary system clock |
| clk_scan | input | 1 | Slower scan/test clock |
| sel_scan | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| en_n | input | 1 | Active-low gate enable, sampled on the falling edge of the selected clock |
| rst | input | 1 | Asynchronous active-high reset; sets the gate to disabled |
| out_t | output | NUM_OUT | True clock outputs |
| out_c | output | NUM_OUT | Complement clock outputs |

## Verification
The bench builds the block with the default of five output pairs. It drives the system clock with a 5 ns half period and the scan clock with a 17 ns half period. Because these half periods do not share a common rhythm, randomly timed enable toggles land in every phase of both clocks, both just before falling edges and in mid-high phase. With outputs checked every nanosecond and every high pulse width measured, this brings the deferred-enable behaviour, runt-free switching, select sweeps while disabled, and a mid-pulse asynchronous reset all within reach.

// File: rtl/gcf_pkg.sv
`timescale 1ns/10ps
package gcf_pkg;
  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_SCAN = 1'b1
  } src_e;

  // Source routing: scan clock when SRC_SCAN, system clock otherwise.
  function automatic logic route_clk(input src_e src, input logic c_sys, input logic c_scan);
    return (src == SRC_SCAN) ? c_scan : c_sys;
  endfunction

  // Gate: the clock passes only while the registered "off" state is clear.
  function automatic logic gate_clk(input logic clk, input logic off);
    return clk & ~off;
  endfunction
endpackage

// File: rtl/gcf_mux.sv
`timescale 1ns/10ps
module gcf_mux
  import gcf_pkg::*;
(
  input  logic clk_sys,
  input  logic clk_scan,
  input  logic sel_scan,
  output logic clk_out
);
  src_e src;

  assign src     = src_e'(sel_scan);
  assign clk_out = route_clk(src, clk_sys, clk_scan);
endmodule

// File: rtl/gcf_en_sync.sv
`timescale 1ns/10ps
module gcf_en_sync #(
  parameter logic OFF_AT_RESET = 1'b1
) (
  input  logic clk_in,
  input  logic rst,
  input  logic en_n,
  output logic off_q
);
  // Falling-edge capture: the gate state can only move while clk_in is low.
  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) off_q <= OFF_AT_RESET;
    else     off_q <= en_n;
  end

  // R4: the state held over a whole clock period is the en_n seen at the previous fall.
  p_sample_fall_r4: assert property (@(negedge clk_in) disable iff (rst)
    1'b1 |=> (off_q == $past(en_n)))
    else $error("p_sample_fall_r4");

  // R5: the gate state never moves while the selected clock is high.
  always @(off_q) begin
    if (!rst) begin
      p_no_change_high_r5: assert (!clk_in)
        else $error("p_no_change_high_r5");
    end
  end
endmodule

// File: rtl/gcf_fanout.sv
`timescale 1ns/10ps
module gcf_fanout
  import gcf_pkg::*;
#(
  parameter int NUM_OUT = 5
) (
  input  logic               clk_in,
  input  logic               off,
  input  logic               rst,
  output logic [NUM_OUT-1:0] out_t,
  output logic [NUM_OUT-1:0] out_c
);
  localparam logic [NUM_OUT-1:0] ALL_ONES = {NUM_OUT{1'b1}};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic lane;
    assign lane     = gate_clk(clk_in, off);
    assign out_t[g] = lane;
    assign out_c[g] = ~lane;
  end

  // R3: a high phase spent disabled leaves every true output low.
  p_off_low_r3: assert property (@(negedge clk_in) disable iff (rst)
    off |-> (out_t == '0))
    else $error("p_off_low_r3");

  // R9: a high phase spent enabled drives every lane high together.
  p_on_high_r9: assert property (@(negedge clk_in) disable iff (rst)
    !off |-> (out_t == ALL_ONES))
    else $error("p_on_high_r9");
endmodule

// File: rtl/gclk_fanout.sv
`timescale 1ns/10ps
module gclk_fanout #(
  parameter int NUM_OUT = 5
) (
  input  logic               clk_sys,
  input  logic               clk_scan,
  input  logic               sel_scan,
  input  logic               en_n,
  input  logic               rst,
  output logic [NUM_OUT-1:0] out_t,
  output logic [NUM_OUT-1:0] out_c
);
  localparam logic [NUM_OUT-1:0] ALL_ONES = {NUM_OUT{1'b1}};

  logic clk_sel;   // muxed clock, brought out for the assertions
  logic gate_off;  // registered disable state

  gcf_mux u_mux (
    .clk_sys  (clk_sys),
    .clk_scan (clk_scan),
    .sel_scan (sel_scan),
    .clk_out  (clk_sel)
  );

  gcf_en_sync #(.OFF_AT_RESET(1'b1)) u_en (
    .clk_in (clk_sel),
    .rst    (rst),
    .en_n   (en_n),
    .off_q  (gate_off)
  );

  gcf_fanout #(.NUM_OUT(NUM_OUT)) u_fan (
    .clk_in (clk_sel),
    .off    (gate_off),
    .rst    (rst),
    .out_t  (out_t),
    .out_c  (out_c)
  );

  // R1: system clock high phase reaches the outputs when it is selected and enabled.
  p_sel_sys_r1: assert property (@(negedge clk_sys) disable iff (rst)
    (!sel_scan && !gate_off) |-> (out_t == ALL_ONES))
    else $error("p_sel_sys_r1");

  // R2: scan clock high phase reaches the outputs when it is selected and enabled.
  p_sel_scan_r2: assert property (@(negedge clk_scan) disable iff (rst)
    (sel_scan && !gate_off) |-> (out_t == ALL_ONES))
    else $error("p_sel_scan_r2");
endmodule

// File: tb/gclk_fanout_bench.sv
`timescale 1ns/10ps
module gclk_fanout_bench;
  localparam int  N         = 5;
  localparam real SYS_HALF  = 5.0;
  localparam real SCAN_HALF = 17.0;

  logic clk_sys = 1'b0, clk_scan = 1'b0, sel = 1'b0, en_n = 1'b0, rst = 1'b0, run = 1'b1;
  logic [N-1:0] out_t, out_c;
  int checks = 0, errors = 0;
  logic sample_on = 1'b1, runt_on = 1'b0;
  real t_rise = 0.0;

  gclk_fanout #(.NUM_OUT(N)) u_gclk_fanout (
    .clk_sys(clk_sys), .clk_scan(clk_scan), .sel_scan(sel), .en_n(en_n),
    .rst(rst), .out_t(out_t), .out_c(out_c)
  );

  always #(SYS_HALF)  if (run) clk_sys  = ~clk_sys;
  always #(SCAN_HALF) if (run) clk_scan = ~clk_scan;

  // Reference view built from the requirements: selected clock and the gate state
  // latched from en_n at each fall of that clock (R4), forced off by reset (R7).
  logic bclk;
  logic exp_off = 1'b1;
  assign bclk = sel ? clk_scan : clk_sys;
  always @(negedge bclk or posedge rst) begin
    if (rst) exp_off <= 1'b1;
    else     exp_off <= en_n;
  end

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Continuous sampling between edges (edges on whole ns, drives on .25, samples on .75).
  initial begin
    #0.75;
    forever begin
      #1;
      if (sample_on) begin
        logic [N-1:0] exp_t;
        string tag;
        exp_t = (bclk && !exp_off) ? {N{1'b1}} : '0;
        if (rst)                tag = "R7";
        else if (en_n != exp_off) tag = "R4";
        else if (exp_off)       tag = "R3";
        else if (sel)           tag = "R2";
        else                    tag = "R1";
        check(out_t == exp_t, tag, out_t, exp_t);
        check(out_c == ~out_t, "R6", out_c, ~out_t);
        check((out_t == '0) || (out_t == {N{1'b1}}), "R9", out_t, {N{out_t[0]}});
      end
    end
  end

  // R5: high pulse width measurement on a true output.
  always @(posedge out_t[2]) t_rise = $realtime;
  always @(negedge out_t[2]) begin
    if (runt_on) begin
      real w, half;
      w    = $realtime - t_rise;
      half = sel ? SCAN_HALF : SYS_HALF;
      checks++;
      if (w < half - 0.01 || w > half + 0.01) begin
        errors++;
        $display("FAIL R5 at %0t: actual pulse %0f ns expected %0f ns", $time, w, half);
      end
    end
  end

  task automatic toggle_en(input int n);
    for (int i = 0; i < n; i++) begin
      #($urandom_range(1, 23));
      en_n = ~en_n;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(7));
    #0.1 rst = 1'b1;
    #3.65;
    // R7: reset state
    check(out_t == '0, "R7", out_t, '0);
    check(out_c == {N{1'b1}}, "R7", out_c, {N{1'b1}});
    #16.5;                           // now t = 20.25
    rst = 1'b0;

    // Phase A: system clock, random enable toggles (R1, R4, R5)
    runt_on = 1'b1;
    toggle_en(200);
    runt_on = 1'b0;
    en_n = 1'b0;
    #60;
    sel = 1'b1;
    #80;
    // Phase B: scan clock, random enable toggles (R2, R4, R5)
    runt_on = 1'b1;
    toggle_en(200);
    runt_on = 1'b0;

    // Phase C: disabled, select swept (R3)
    en_n = 1'b1;
    #80;
    for (int i = 0; i < 40; i++) begin
      #($urandom_range(1, 19));
      sel = ~sel;
    end
    sel = 1'b0;
    en_n = 1'b0;
    #60;

    // Phase D: asynchronous reset in the middle of a high pulse (R7)
    @(posedge clk_sys);
    #1.25;
    check(out_t == {N{1'b1}}, "R1", out_t, {N{1'b1}});
    rst = 1'b1;
    #0.5;
    check(out_t == '0, "R7", out_t, '0);
    #20;
    rst = 1'b0;
    #60;

    // Phase E: everything low (R8)
    run = 1'b0;
    #1;
    clk_sys = 1'b0;
    clk_scan = 1'b0;
    sel = 1'b0;
    en_n = 1'b0;
    #20;
    check(out_t == '0, "R8", out_t, '0);
    check(out_c == {N{1'b1}}, "R8", out_c, {N{1'b1}});
    finish_run();
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog at %0t: actual running expected finished", $time);
    finish_run();
  end
endmodule